// File: doc/BRIEF.md
# Dual-Lane Fingerprint Comparator

Two redundant cores execute the same program. Each reports every change it makes to architectural state as one update per cycle: a kind bit (register write or memory store), a destination and a value. This block gives each core its own lane. The lane folds each accepted update into a 16-bit CRC signature. Only the two signatures are compared, and only at interval boundaries, so the comparison path carries two short words per interval instead of every update.

A compare happens in one of two ways. It is forced automatically once both lanes have absorbed a fixed number of updates, or it happens at once when an external checkpoint tick arrives. Because of this, an error in either core is reported within one interval of updates.

Each compare produces a one-cycle result strobe together with the two signatures that were compared. A disagreement raises a one-cycle error pulse and sets an error flag that stays set until reset. After every compare both signatures restart from the seed. A lane that gets a full interval ahead of its partner is held off with its ready signal until the partner catches up.

Top module: `fp_dmr_compare`

## Requirements
- R1: Out of reset both signatures equal the seed 0xFFFF, both lane counts are zero, both ready outputs are high, cmp_valid, err_pulse and err_sticky are low, and fp_a_out and fp_b_out read 0xFFFF.
- R2: Each accepted update is folded into its lane's signature as a 25-bit message {kind, dest[7:0], data[15:0]}, most significant bit first. The fold is a CRC-16 with generator 0x1021, no reflection and no final inversion. A lane accepts at most one update per cycle.
- R3: An update is taken only on a clock edge where both its valid and its ready are high. An update offered while ready is low has no effect on the signature.
- R4: When both lanes hold INTERVAL updates (default 8), a compare is performed on the next clock edge.
- R5: A high ckpt_tick at a clock edge forces a compare at that edge, whatever the lane counts are.
- R6: A compare loads fp_a_out and fp_b_out with the lane A and lane B signatures and sets cmp_match to their equality. cmp_valid is high for exactly the following cycle. fp_a_out, fp_b_out and cmp_match hold until the next compare.
- R7: The compare edge returns both signatures to 0xFFFF and both counts to zero. A compare with no updates since the previous one therefore reports 0xFFFF on both outputs and a match.
- R8: err_pulse is high for exactly the cycle in which cmp_valid is high and cmp_match is low, and low in every other cycle.
- R9: err_sticky is set by the first mismatching compare and stays set until reset. Later matching compares do not clear it.
- R10: A lane's ready output is low while that lane holds INTERVAL updates. Both ready outputs are also low in any cycle in which a compare fires (ckpt_tick high, or both lanes full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Lane A update present |
| a_ready | output | 1 | Lane A can take an update this cycle |
| a_kind | input | 1 | Lane A kind: 0 register write, 1 memory store |
| a_dest | input | DEST_W | Lane A destination register or address |
| a_data | input | DATA_W | Lane A written value |
| b_valid | input | 1 | Lane B update present |
| b_ready | output | 1 | Lane B can take an update this cycle |
| b_kind | input | 1 | Lane B kind: 0 register write, 1 memory store |
| b_dest | input | DEST_W | Lane B destination register or address |
| b_data | input | DATA_W | Lane B written value |
| ckpt_tick | input | 1 | Forces a compare at this edge |
| cmp_valid | output | 1 | One-cycle strobe: a compare result is present |
| cmp_match | output | 1 | The last two signatures compared were equal |
| err_pulse | output | 1 | One-cycle pulse on a mismatching compare |
| err_sticky | output | 1 | Set by any mismatch, cleared only by reset |
| fp_a_out | output | 16 | Lane A signature at the last compare |
| fp_b_out | output | 16 | Lane B signature at the last compare |

## Verification
The properties assume the update fields are stable and defined whenever valid is high. They also assume that ckpt_tick is a plain synchronous level. They are checked against internal lane counts and signatures, which can never exceed one interval or differ from the seed right after a compare. The stimulus drives every input just after the falling edge and keeps payloads fixed until the update is taken. It throttles the two lanes at different rates so that the faster lane fills and waits, and it raises ckpt_tick both with valid updates pending and with empty lanes.

// File: rtl/fp_dmr_pkg.sv
package fp_dmr_pkg;
    localparam int          FP_W    = 16;
    localparam logic [15:0] FP_POLY = 16'h1021;
    localparam logic [15:0] FP_SEED = 16'hFFFF;
    typedef logic [FP_W-1:0] fp_t;
endpackage

// File: rtl/fp_crc_fold.sv
// Combinational fold of one message into a running CRC, MSB first.
module fp_crc_fold
    import fp_dmr_pkg::*;
#(
    parameter int MSG_W = 25
) (
    input  fp_t              crc_in,
    input  logic [MSG_W-1:0] msg,
    output fp_t              crc_out
);
    fp_t chain [MSG_W+1];

    assign chain[0] = crc_in;

    for (genvar i = 0; i < MSG_W; i++) begin : g_bit
        logic feedback;
        assign feedback     = chain[i][FP_W-1] ^ msg[MSG_W-1-i];
        assign chain[i+1]   = {chain[i][FP_W-2:0], 1'b0} ^ (feedback ? FP_POLY : '0);
    end

    assign crc_out = chain[MSG_W];
endmodule

// File: rtl/fp_lane.sv
// One redundant stream: signature register and update counter.
module fp_lane
    import fp_dmr_pkg::*;
#(
    parameter int MSG_W    = 25,
    parameter int INTERVAL = 8,
    parameter int CNT_W    = $clog2(INTERVAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             clear,
    input  logic [MSG_W-1:0] msg,
    output fp_t              fp_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             full
);
    typedef struct packed {
        fp_t              fp;
        logic [CNT_W-1:0] cnt;
    } lane_s;

    lane_s lane_d, lane_q;
    fp_t   folded;

    fp_crc_fold #(.MSG_W(MSG_W)) u_fold (
        .crc_in (lane_q.fp),
        .msg    (msg),
        .crc_out(folded)
    );

    always_comb begin
        lane_d = lane_q;
        if (clear) begin
            lane_d.fp  = FP_SEED;
            lane_d.cnt = '0;
        end else if (take) begin
            lane_d.fp  = folded;
            lane_d.cnt = lane_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q.fp  <= FP_SEED;
            lane_q.cnt <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign fp_q  = lane_q.fp;
    assign cnt_q = lane_q.cnt;
    assign full  = (lane_q.cnt == CNT_W'(INTERVAL));
endmodule

// File: rtl/fp_dmr_compare.sv
// Dual-lane signature comparator with interval and tick triggered compares.
module fp_dmr_compare
    import fp_dmr_pkg::*;
#(
    parameter int DEST_W   = 8,
    parameter int DATA_W   = 16,
    parameter int INTERVAL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic              a_kind,
    input  logic [DEST_W-1:0] a_dest,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic              b_kind,
    input  logic [DEST_W-1:0] b_dest,
    input  logic [DATA_W-1:0] b_data,
    input  logic              ckpt_tick,
    output logic              cmp_valid,
    output logic              cmp_match,
    output logic              err_pulse,
    output logic              err_sticky,
    output logic [15:0]       fp_a_out,
    output logic [15:0]       fp_b_out
);
    localparam int MSG_W   = 1 + DEST_W + DATA_W;
    localparam int CNT_W   = $clog2(INTERVAL + 1);
    localparam int N_LANES = 2;

    typedef struct packed {
        logic cmp_valid;
        logic cmp_match;
        logic err_pulse;
        logic err_sticky;
        fp_t  fp_a;
        fp_t  fp_b;
    } res_s;

    logic [N_LANES-1:0]            lane_valid;
    logic [N_LANES-1:0]            lane_ready;
    logic [N_LANES-1:0]            lane_take;
    logic [N_LANES-1:0]            lane_full;
    logic [N_LANES-1:0][MSG_W-1:0] lane_msg;
    logic [N_LANES-1:0][FP_W-1:0]  lane_fp;
    logic [N_LANES-1:0][CNT_W-1:0] lane_cnt;
    logic                          fire;
    res_s                          res_d, res_q;

    assign lane_valid = {b_valid, a_valid};
    assign lane_msg[0] = {a_kind, a_dest, a_data};
    assign lane_msg[1] = {b_kind, b_dest, b_data};

    // Compare when forced by the tick or when every lane has a full interval.
    assign fire = ckpt_tick || (&lane_full);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_ready[g] = !lane_full[g] && !fire;
        assign lane_take[g]  = lane_valid[g] && lane_ready[g];

        fp_lane #(
            .MSG_W   (MSG_W),
            .INTERVAL(INTERVAL),
            .CNT_W   (CNT_W)
        ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .take (lane_take[g]),
            .clear(fire),
            .msg  (lane_msg[g]),
            .fp_q (lane_fp[g]),
            .cnt_q(lane_cnt[g]),
            .full (lane_full[g])
        );
    end

    assign a_ready = lane_ready[0];
    assign b_ready = lane_ready[1];

    always_comb begin
        res_d           = res_q;
        res_d.cmp_valid = 1'b0;
        res_d.err_pulse = 1'b0;
        if (fire) begin
            res_d.cmp_valid  = 1'b1;
            res_d.fp_a       = lane_fp[0];
            res_d.fp_b       = lane_fp[1];
            res_d.cmp_match  = (lane_fp[0] == lane_fp[1]);
            res_d.err_pulse  = (lane_fp[0] != lane_fp[1]);
            res_d.err_sticky = res_q.err_sticky || (lane_fp[0] != lane_fp[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q.cmp_valid  <= 1'b0;
            res_q.cmp_match  <= 1'b0;
            res_q.err_pulse  <= 1'b0;
            res_q.err_sticky <= 1'b0;
            res_q.fp_a       <= FP_SEED;
            res_q.fp_b       <= FP_SEED;
        end else begin
            res_q <= res_d;
        end
    end

    assign cmp_valid  = res_q.cmp_valid;
    assign cmp_match  = res_q.cmp_match;
    assign err_pulse  = res_q.err_pulse;
    assign err_sticky = res_q.err_sticky;
    assign fp_a_out   = res_q.fp_a;
    assign fp_b_out   = res_q.fp_b;
endmodule

// File: rtl/fp_dmr_checker.sv
module fp_dmr_checker #(
    parameter int INTERVAL = 8,
    parameter int CNT_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  a_ready,
    input logic                  b_ready,
    input logic                  ckpt_tick,
    input logic                  cmp_valid,
    input logic                  cmp_match,
    input logic                  err_pulse,
    input logic                  err_sticky,
    input logic [15:0]           fp_a_out,
    input logic [15:0]           fp_b_out,
    input logic [1:0][15:0]      lane_fp,
    input logic [1:0][CNT_W-1:0] lane_cnt
);
    assert_tick_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_tick |-> (!a_ready && !b_ready));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_cnt[0] <= CNT_W'(INTERVAL)) && (lane_cnt[1] <= CNT_W'(INTERVAL)));

    assert_full_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_cnt[0] == CNT_W'(INTERVAL)) |-> !a_ready);

    assert_match_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cmp_match == (fp_a_out == fp_b_out)));

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |-> ($stable(fp_a_out) && $stable(fp_b_out) && $stable(cmp_match)));

    assert_reseed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (lane_fp[0] == 16'hFFFF && lane_fp[1] == 16'hFFFF
                       && lane_cnt[0] == '0 && lane_cnt[1] == '0));

    assert_pulse_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (cmp_valid && !cmp_match));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);

    assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

bind fp_dmr_compare fp_dmr_checker #(
    .INTERVAL(INTERVAL),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_ready   (a_ready),
    .b_ready   (b_ready),
    .ckpt_tick (ckpt_tick),
    .cmp_valid (cmp_valid),
    .cmp_match (cmp_match),
    .err_pulse (err_pulse),
    .err_sticky(err_sticky),
    .fp_a_out  (fp_a_out),
    .fp_b_out  (fp_b_out),
    .lane_fp   (lane_fp),
    .lane_cnt  (lane_cnt)
);

// File: tb/fp_dmr_compare_tb.sv
module fp_dmr_compare_tb;
    localparam int N = 8;

    typedef struct {
        logic [15:0] fa;
        logic [15:0] fb;
        logic        match;
        logic        sticky;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic        a_ready, b_ready;
    logic        a_kind = 1'b0, b_kind = 1'b0;
    logic [7:0]  a_dest = '0, b_dest = '0;
    logic [15:0] a_data = '0, b_data = '0;
    logic        ckpt_tick = 1'b0;
    logic        cmp_valid, cmp_match, err_pulse, err_sticky;
    logic [15:0] fp_a_out, fp_b_out;

    always #4 clk = ~clk;

    fp_dmr_compare u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_kind(a_kind), .a_dest(a_dest), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_kind(b_kind), .b_dest(b_dest), .b_data(b_data),
        .ckpt_tick(ckpt_tick), .cmp_valid(cmp_valid), .cmp_match(cmp_match),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .fp_a_out(fp_a_out), .fp_b_out(fp_b_out)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    int          n_cmp = 0;
    bit          done = 1'b0;
    logic [24:0] qa[$];
    logic [24:0] qb[$];
    exp_t        sb[$];
    int          a_gap = 0, b_gap = 0, a_ph = 0, b_ph = 0;
    logic [15:0] m_fa = 16'hFFFF, m_fb = 16'hFFFF;
    int          m_ca = 0, m_cb = 0;
    logic        m_sticky = 1'b0;

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [24:0] m);
        for (int i = 24; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ m[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Stream drivers: present the head of each queue, throttled by a gap.
    initial forever begin
        @(negedge clk);
        a_ph++;
        if (qa.size() > 0 && a_ph > a_gap) begin
            a_valid = 1'b1;
            {a_kind, a_dest, a_data} = qa[0];
        end else a_valid = 1'b0;
    end

    initial forever begin
        @(negedge clk);
        b_ph++;
        if (qb.size() > 0 && b_ph > b_gap) begin
            b_valid = 1'b1;
            {b_kind, b_dest, b_data} = qb[0];
        end else b_valid = 1'b0;
    end

    // Scoreboard: monitor the previous edge's results, then predict the next edge.
    initial forever begin
        @(negedge clk);
        #2;
        if (!rst_n) begin
            m_fa = 16'hFFFF; m_fb = 16'hFFFF; m_ca = 0; m_cb = 0; m_sticky = 1'b0;
            sb.delete();
        end else begin
            bit   fire, exp_ra, exp_rb, acc_a, acc_b;
            exp_t e;
            if (cmp_valid) begin
                n_cmp++;
                if (sb.size() == 0) begin
                    check(1'b0, "R6 unexpected compare", 32'(cmp_valid), 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(fp_a_out == e.fa, "R6 (R2) lane A signature", 32'(fp_a_out), 32'(e.fa));
                    check(fp_b_out == e.fb, "R6 (R2) lane B signature", 32'(fp_b_out), 32'(e.fb));
                    check(cmp_match == e.match, "R6 match flag", 32'(cmp_match), 32'(e.match));
                    check(err_pulse == !e.match, "R8 error pulse", 32'(err_pulse), 32'(!e.match));
                    check(err_sticky == e.sticky, "R9 sticky flag", 32'(err_sticky), 32'(e.sticky));
                end
            end else begin
                check(err_pulse == 1'b0, "R8 pulse outside compare", 32'(err_pulse), 32'd0);
            end
            fire   = ckpt_tick || (m_ca == N && m_cb == N);
            exp_ra = (m_ca < N) && !fire;
            exp_rb = (m_cb < N) && !fire;
            check(a_ready == exp_ra, "R10 lane A ready", 32'(a_ready), 32'(exp_ra));
            check(b_ready == exp_rb, "R10 lane B ready", 32'(b_ready), 32'(exp_rb));
            acc_a = a_valid && a_ready;
            acc_b = b_valid && b_ready;
            if (fire) begin
                e.fa = m_fa; e.fb = m_fb; e.match = (m_fa == m_fb);
                m_sticky = m_sticky || (m_fa != m_fb);
                e.sticky = m_sticky;
                sb.push_back(e);
                m_fa = 16'hFFFF; m_fb = 16'hFFFF; m_ca = 0; m_cb = 0;
            end else begin
                if (acc_a) begin
                    m_fa = crc_upd(m_fa, qa[0]); m_ca++; void'(qa.pop_front()); a_ph = 0;
                end
                if (acc_b) begin
                    m_fb = crc_upd(m_fb, qb[0]); m_cb++; void'(qb.pop_front()); b_ph = 0;
                end
            end
        end
    end

    task automatic push_pair(input int count, input int seed, input int bad_idx, input bit bad_kind);
        for (int i = 0; i < count; i++) begin
            logic [24:0] m;
            m = {1'(i & 1), 8'(seed + i * 3), 16'(seed * 257 + i * 4099)};
            qa.push_back(m);
            if (i == bad_idx) m = bad_kind ? (m ^ 25'h1000000) : (m ^ 25'h0000010);
            qb.push_back(m);
        end
    endtask

    task automatic drain();
        while (qa.size() > 0 || qb.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        ckpt_tick = 1'b1;
        @(negedge clk);
        ckpt_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #3;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(a_ready && b_ready, "R1 ready after reset", 32'({a_ready, b_ready}), 32'd3);
        check(!cmp_valid && !err_pulse, "R1 strobes low", 32'({cmp_valid, err_pulse}), 32'd0);
        check(!err_sticky, "R1 sticky clear", 32'(err_sticky), 32'd0);
        check(fp_a_out == 16'hFFFF && fp_b_out == 16'hFFFF, "R1 signature outputs",
              32'({fp_a_out, fp_b_out}), 32'hFFFFFFFF);

        // R4 one full matching interval, both lanes at full rate
        push_pair(N, 5, -1, 1'b0);
        drain();
        check(n_cmp == 1, "R4 automatic compare count", 32'(n_cmp), 32'd1);

        // R10 lane B slower: lane A fills and waits, two intervals
        b_gap = 3;
        push_pair(2 * N, 17, -1, 1'b0);
        drain();
        b_gap = 0;
        check(n_cmp == 3, "R4 R10 compares with stalled lane", 32'(n_cmp), 32'd3);

        // R5 partial interval closed by a tick
        push_pair(3, 40, -1, 1'b0);
        drain();
        tick();
        check(n_cmp == 4, "R5 tick-forced compare", 32'(n_cmp), 32'd4);

        // R7 tick with no updates since last compare
        tick();
        check(fp_a_out == 16'hFFFF && fp_b_out == 16'hFFFF && cmp_match,
              "R7 empty compare reports seed", 32'({fp_a_out, fp_b_out}), 32'hFFFFFFFF);

        // R8 R9 data mismatch in the fifth update
        push_pair(N, 77, 4, 1'b0);
        drain();
        check(err_sticky == 1'b1, "R9 sticky after mismatch", 32'(err_sticky), 32'd1);

        // R9 matching interval does not clear the flag
        push_pair(N, 90, -1, 1'b0);
        drain();
        check(err_sticky == 1'b1 && cmp_match, "R9 sticky kept after match",
              32'({err_sticky, cmp_match}), 32'd3);

        // R2 updates differing only in kind bit
        push_pair(2, 120, 1, 1'b1);
        drain();
        tick();
        check(cmp_match == 1'b0, "R2 kind bit is hashed", 32'(cmp_match), 32'd0);

        // R3 R10 tick while updates are offered: they wait, then land next interval
        push_pair(2, 150, -1, 1'b0);
        ckpt_tick = 1'b1;
        @(negedge clk);
        ckpt_tick = 1'b0;
        drain();
        tick();
        check(cmp_match == 1'b1, "R3 offered updates during tick", 32'(cmp_match), 32'd1);

        // R9 reset clears the flag
        do_reset();
        check(err_sticky == 1'b0, "R9 reset clears sticky", 32'(err_sticky), 32'd0);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R6 all expected compares seen", 32'(sb.size()), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule